// File: doc/BRIEF.md
# Sequenced Protected Configuration Register

This block holds the 8-bit control register of a serial memory device. The register has two volatile enable latches and a set of nonvolatile fields: a two-bit watchdog period select and a three-bit block-protect select. It sits behind a byte-level bus front end that has already decoded start, data and stop events for register writes. The block decides, byte by byte, whether to acknowledge. It applies an accepted byte when the stop arrives. A change to the nonvolatile fields runs a modelled commit whose length is set by a parameter.

The nonvolatile fields can change only through a fixed unlock sequence. The first transaction writes 02h to open the write latch. The second writes 06h to open the register latch. The third writes the new field values. A completed commit closes the register latch again. So does any attempt to write a protected array address. The block also decodes the block-protect field against a memory-write address and flags writes that fall in the protected range. It returns the register byte on request and drives the committed watchdog select to the watchdog counter.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset, the write latch and the register latch are 0, the watchdog select is 11, the protect select is 000 and busy is low. A read returns 60h. The read-back layout from bit 7 down to bit 0 is: 0, WD1, WD0, BP1, BP0, register latch, write latch, BP2.
- R2: While the write latch is 0, only the byte 02h is acknowledged, and at stop it sets the write latch. Every other byte is NACKed and changes nothing.
- R3: While the write latch is 1 and the register latch is 0, three bytes are acknowledged. 02h leaves the state as it is, 00h clears the write latch, and 06h sets the register latch. Every other byte is NACKed and changes nothing.
- R4: While the register latch is 1, a byte with bit 7 = 0, bit 2 = 0 and bit 1 = 1 is acknowledged. At stop it clears the register latch and starts a commit of WD = bits 6:5 and BP = {bit 0, bits 4:3}.
- R5: While the register latch is 1, a byte with bit 7 = 0, bit 2 = 1 and bit 1 = 1 is acknowledged and changes nothing. Any other byte is NACKed and changes nothing.
- R6: A second data byte in one register-write transaction is NACKed, and the whole transaction is then discarded at stop.
- R7: Busy is high for exactly COMMIT_CYC cycles after the stop that starts a commit. Every data byte received while busy is high is NACKed. The old field values stay visible until busy falls.
- R8: A read request returns the register byte, with rd_vld set, one cycle later. Reads placed between the unlock steps leave the sequence intact.
- R9: A memory-write strobe raises wp_hit one cycle later exactly when the address lies in the range selected by BP: 000 none, 001 upper quarter, 010 upper half, 011 all, 1xx the lowest PAGE_B << BP[1:0] addresses.
- R10: A memory-write attempt to a protected address clears the register latch.
- R11: wd_sel always equals the committed watchdog select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start of a register-write transaction |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | Stop strobe ending the transaction |
| mem_wr_vld | input | 1 | Memory-write attempt strobe |
| mem_wr_addr | input | AW | Memory-write address |
| rd_req | input | 1 | Register read request |
| ack_vld | output | 1 | Acknowledge decision valid, one cycle after a byte |
| ack | output | 1 | 1 = acknowledge, 0 = NACK |
| busy | output | 1 | Nonvolatile commit in progress |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Register byte |
| wd_sel | output | 2 | Committed watchdog period select |
| wp_hit | output | 1 | Memory-write attempt hit a protected address |

## Verification
The assertions check these rules on every cycle: no byte is acknowledged while busy, no byte other than 02h is acknowledged while the write latch is closed, the register latch is never open without the write latch, a protect hit always leaves the register latch closed, the watchdog select holds steady through a commit, and read and hit pulses follow their requests. Other behaviours are visible only in the bench's scenarios. These are the full byte-by-byte acceptance tables in each latch state, the exact commit length, the discard of a two-byte transaction, the unlock sequence with reads placed between its steps, and the address decode for every protect setting.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [2:0] {
    ACT_NOP,
    ACT_WEL_ON,
    ACT_WEL_OFF,
    ACT_RWEL_ON,
    ACT_COMMIT
  } act_e;

  typedef struct packed {
    logic ok;
    act_e act;
  } verdict_t;

  // Acceptance decision for one register byte in the present latch state.
  function automatic verdict_t judge(input logic [7:0] b, input logic wel, input logic rwel);
    verdict_t v;
    v.ok  = 1'b0;
    v.act = ACT_NOP;
    if (rwel) begin
      if (!b[7] && b[1]) begin
        v.ok  = 1'b1;
        v.act = b[2] ? ACT_NOP : ACT_COMMIT;
      end
    end else if (wel) begin
      case (b)
        8'h02:   begin v.ok = 1'b1; v.act = ACT_WEL_ON;  end
        8'h00:   begin v.ok = 1'b1; v.act = ACT_WEL_OFF; end
        8'h06:   begin v.ok = 1'b1; v.act = ACT_RWEL_ON; end
        default: v.ok = 1'b0;
      endcase
    end else if (b == 8'h02) begin
      v.ok  = 1'b1;
      v.act = ACT_WEL_ON;
    end
    return v;
  endfunction

endpackage

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_start,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       stop,
  input  logic       busy,
  input  logic       wel,
  input  logic       rwel,
  output logic       ack_vld,
  output logic       ack,
  output logic       apply,
  output act_e       apply_act,
  output logic [7:0] apply_byte
);

  logic     in_txn;
  logic     seen;
  logic     pend_ok;
  verdict_t vd;

  assign vd    = judge(byte_in, wel, rwel);
  assign apply = stop && !wr_start && in_txn && pend_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_txn     <= 1'b0;
      seen       <= 1'b0;
      pend_ok    <= 1'b0;
      apply_act  <= ACT_NOP;
      apply_byte <= 8'h00;
      ack_vld    <= 1'b0;
      ack        <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      if (wr_start) begin
        in_txn  <= 1'b1;
        seen    <= 1'b0;
        pend_ok <= 1'b0;
      end else if (byte_vld && in_txn) begin
        ack_vld <= 1'b1;
        seen    <= 1'b1;
        if (busy || seen) begin
          ack     <= 1'b0;
          pend_ok <= 1'b0;
        end else begin
          ack        <= vd.ok;
          pend_ok    <= vd.ok;
          apply_act  <= vd.act;
          apply_byte <= byte_in;
        end
      end else if (stop) begin
        in_txn  <= 1'b0;
        pend_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfg_lock_commit.sv
module cfg_lock_commit
  import cfg_lock_pkg::*;
#(
  parameter int COMMIT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       apply,
  input  act_e       apply_act,
  input  logic [7:0] apply_byte,
  input  logic       prot_clr,
  output logic       wel,
  output logic       rwel,
  output logic [1:0] wd,
  output logic [2:0] bp,
  output logic       busy
);

  localparam int CW = $clog2(COMMIT_CYC + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    sh_wd;
  logic [2:0]    sh_bp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel   <= 1'b0;
      rwel  <= 1'b0;
      wd    <= 2'b11;
      bp    <= 3'b000;
      sh_wd <= 2'b11;
      sh_bp <= 3'b000;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (apply) begin
        case (apply_act)
          ACT_WEL_ON:  wel <= 1'b1;
          ACT_WEL_OFF: wel <= 1'b0;
          ACT_RWEL_ON: begin wel <= 1'b1; rwel <= 1'b1; end
          ACT_COMMIT: begin
            rwel  <= 1'b0;
            sh_wd <= apply_byte[6:5];
            sh_bp <= {apply_byte[0], apply_byte[4:3]};
            busy  <= 1'b1;
            cnt   <= CW'(COMMIT_CYC - 1);
          end
          default: ;
        endcase
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          wd   <= sh_wd;
          bp   <= sh_bp;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (prot_clr) rwel <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_lock_prot.sv
module cfg_lock_prot #(
  parameter int AW     = 9,
  parameter int PAGE_B = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bp,
  input  logic          mem_wr_vld,
  input  logic [AW-1:0] mem_wr_addr,
  output logic          prot_clr,
  output logic          wp_hit
);

  localparam int DEPTH = 1 << AW;
  localparam int Q_UP  = (DEPTH / 4) * 3;
  localparam int H_UP  = DEPTH / 2;

  logic in_range;
  int   a;

  assign a = int'(mem_wr_addr);

  always_comb begin
    case (bp)
      3'b000:  in_range = 1'b0;
      3'b001:  in_range = (a >= Q_UP);
      3'b010:  in_range = (a >= H_UP);
      3'b011:  in_range = 1'b1;
      default: in_range = (a < (PAGE_B << bp[1:0]));
    endcase
  end

  assign prot_clr = mem_wr_vld && in_range;

  always_ff @(posedge clk) begin
    if (rst) wp_hit <= 1'b0;
    else     wp_hit <= prot_clr;
  end

endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
#(
  parameter int AW         = 9,
  parameter int PAGE_B     = 16,
  parameter int COMMIT_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          stop,
  input  logic          mem_wr_vld,
  input  logic [AW-1:0] mem_wr_addr,
  input  logic          rd_req,
  output logic          ack_vld,
  output logic          ack,
  output logic          busy,
  output logic          rd_vld,
  output logic [7:0]    rd_data,
  output logic [1:0]    wd_sel,
  output logic          wp_hit
);

  logic       wel, rwel, apply, prot_clr;
  act_e       apply_act;
  logic [7:0] apply_byte;
  logic [1:0] wd;
  logic [2:0] bp;

  cfg_lock_seq u_seq (
    .clk(clk), .rst(rst), .wr_start(wr_start), .byte_vld(byte_vld),
    .byte_in(byte_in), .stop(stop), .busy(busy), .wel(wel), .rwel(rwel),
    .ack_vld(ack_vld), .ack(ack), .apply(apply), .apply_act(apply_act),
    .apply_byte(apply_byte)
  );

  cfg_lock_commit #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk(clk), .rst(rst), .apply(apply), .apply_act(apply_act),
    .apply_byte(apply_byte), .prot_clr(prot_clr), .wel(wel), .rwel(rwel),
    .wd(wd), .bp(bp), .busy(busy)
  );

  cfg_lock_prot #(.AW(AW), .PAGE_B(PAGE_B)) u_prot (
    .clk(clk), .rst(rst), .bp(bp), .mem_wr_vld(mem_wr_vld),
    .mem_wr_addr(mem_wr_addr), .prot_clr(prot_clr), .wp_hit(wp_hit)
  );

  assign wd_sel = wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_data <= {1'b0, wd, bp[1:0], rwel, wel, bp[2]};
    end
  end

endmodule

// File: rtl/cfg_lock_reg_chk.sv
module cfg_lock_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] byte_in,
  input logic       ack_vld,
  input logic       ack,
  input logic       busy,
  input logic       wel,
  input logic       rwel,
  input logic [1:0] wd_sel,
  input logic       wp_hit,
  input logic       mem_wr_vld,
  input logic       rd_req,
  input logic       rd_vld,
  input logic [7:0] rd_data
);

  // R7: no acknowledge for a byte that arrived while busy
  a_r7_nack_busy: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && $past(busy)) |-> !ack);

  // R2: with the write latch closed only 02h is acknowledged
  a_r2_closed_only_02: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack && !$past(wel)) |-> ($past(byte_in) == 8'h02));

  // R3: register latch never open without write latch
  a_r3_rwel_needs_wel: assert property (@(posedge clk) disable iff (rst)
    rwel |-> wel);

  // R10: a protect hit leaves the register latch closed
  a_r10_hit_locks: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> !rwel);

  // R9: hit pulse only follows a write attempt
  a_r9_hit_follows_wr: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> $past(mem_wr_vld));

  // R11: watchdog select holds during a commit
  a_r11_wd_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wd_sel));

  // R8: read pulse follows request, top bit always zero
  a_r8_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(rd_req) && !rd_data[7]));

endmodule

bind cfg_lock_reg cfg_lock_reg_chk u_chk (
  .clk(clk), .rst(rst), .byte_in(byte_in), .ack_vld(ack_vld), .ack(ack),
  .busy(busy), .wel(wel), .rwel(rwel), .wd_sel(wd_sel), .wp_hit(wp_hit),
  .mem_wr_vld(mem_wr_vld), .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data)
);

// File: tb/cfg_lock_reg_tb.sv
module cfg_lock_reg_tb;

  localparam int AW = 9;
  localparam int PAGE_B = 16;
  localparam int CC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 0, byte_vld = 0, stop = 0, mem_wr_vld = 0, rd_req = 0;
  logic [7:0] byte_in = 8'h00;
  logic [AW-1:0] mem_wr_addr = '0;
  logic ack_vld, ack, busy, rd_vld, wp_hit;
  logic [7:0] rd_data;
  logic [1:0] wd_sel;

  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  logic m_wel, m_rwel;
  logic [1:0] m_wd;
  logic [2:0] m_bp;

  always #2.5 clk = ~clk;

  cfg_lock_reg #(.AW(AW), .PAGE_B(PAGE_B), .COMMIT_CYC(CC)) u_dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .byte_vld(byte_vld),
    .byte_in(byte_in), .stop(stop), .mem_wr_vld(mem_wr_vld),
    .mem_wr_addr(mem_wr_addr), .rd_req(rd_req), .ack_vld(ack_vld), .ack(ack),
    .busy(busy), .rd_vld(rd_vld), .rd_data(rd_data), .wd_sel(wd_sel),
    .wp_hit(wp_hit)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte();
    return {1'b0, m_wd, m_bp[1:0], m_rwel, m_wel, m_bp[2]};
  endfunction

  // One register-write transaction with a single byte; returns acknowledge.
  task automatic wr(input logic [7:0] b, output logic a);
    wr_start = 1; tick(); wr_start = 0;
    byte_vld = 1; byte_in = b; tick(); byte_vld = 0;
    a = ack_vld && ack;
    stop = 1; tick(); stop = 0;
  endtask

  task automatic rd_check(input string tag);
    rd_req = 1; tick(); rd_req = 0;
    chk(rd_vld && rd_data == model_byte(), tag, rd_data, model_byte());
    chk(wd_sel == m_wd, "R11 wd_sel", wd_sel, m_wd);
  endtask

  task automatic wait_busy();
    int n = 0;
    while (busy && n < 100) begin n++; tick(); end
    chk(n == CC, "R7 busy length", n, CC);
  endtask

  function automatic logic exp_ack(input logic [7:0] b);
    if (m_rwel) return !b[7] && b[1];
    if (m_wel)  return b == 8'h02 || b == 8'h00 || b == 8'h06;
    return b == 8'h02;
  endfunction

  task automatic apply_model(input logic [7:0] b, output logic commit);
    commit = 0;
    if (m_rwel) begin
      if (!b[2]) begin
        commit = 1; m_rwel = 0;
        m_wd = b[6:5]; m_bp = {b[0], b[4:3]};
      end
    end else if (b == 8'h02) m_wel = 1;
    else if (b == 8'h00) m_wel = 0;
    else if (b == 8'h06) begin m_wel = 1; m_rwel = 1; end
  endtask

  // Accepting write with model update and commit wait.
  task automatic wr_m(input logic [7:0] b, input string tag);
    logic a, e, c;
    e = exp_ack(b);
    wr(b, a);
    chk(a == e, tag, a, e);
    if (e) begin
      apply_model(b, c);
      if (c) wait_busy();
    end
  endtask

  function automatic logic exp_prot(input logic [2:0] p, input int ad);
    case (p)
      3'd0: return 0;
      3'd1: return ad >= 384;
      3'd2: return ad >= 256;
      3'd3: return 1;
      default: return ad < (PAGE_B << p[1:0]);
    endcase
  endfunction

  task automatic commit_val(input logic [1:0] w, input logic [2:0] p);
    if (!m_wel) wr_m(8'h02, "R2 open");
    if (!m_rwel) wr_m(8'h06, "R3 arm");
    wr_m({1'b0, w, p[1:0], 1'b0, 1'b1, p[2]}, "R4 commit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic a, c;
    m_wel = 0; m_rwel = 0; m_wd = 2'b11; m_bp = 3'b000;
    repeat (4) tick();
    rst = 0; tick();

    // R1 reset state
    chk(!busy && !ack_vld && !wp_hit, "R1 reset outputs", busy, 0);
    rd_check("R1 reset read");
    chk(rd_data == 8'h60, "R1 read 60h", rd_data, 8'h60);

    // R2 sweep with write latch closed
    for (int b = 0; b < 256; b++) begin
      wr_m(8'(b), "R2 closed sweep");
      rd_check("R2 state after byte");
      if (m_wel) wr_m(8'h00, "R3 close");
    end

    // R3 sweep with write latch open
    wr_m(8'h02, "R2 open");
    for (int b = 0; b < 256; b++) begin
      wr_m(8'(b), "R3 open sweep");
      rd_check("R3 state after byte");
      if (!m_wel) wr_m(8'h02, "R2 reopen");
      if (m_rwel) wr_m(model_byte() & 8'h7B, "R4 relock");
    end

    // R4 R5 sweep with register latch open
    for (int b = 0; b < 256; b++) begin
      if (!m_rwel) wr_m(8'h06, "R3 arm");
      wr_m(8'(b), "R4 R5 armed sweep");
      rd_check("R5 state after byte");
    end

    // R4 sequence examples: 02,06,06 leaves fields, 02,06,02 clears them
    commit_val(2'b10, 3'b101);
    wr_m(8'h02, "R3 step1"); wr_m(8'h06, "R3 step2"); wr_m(8'h06, "R5 hold");
    chk(m_rwel && m_wd == 2'b10, "R5 hold model", m_wd, 2);
    rd_check("R5 hold read");
    wr_m(8'h02, "R4 clear commit");
    rd_check("R4 clear read");
    chk(rd_data == 8'h02, "R4 cleared byte", rd_data, 8'h02);

    // R8 reads between unlock steps
    wr_m(8'h02, "R8 s1"); rd_check("R8 mid1");
    wr_m(8'h06, "R8 s2"); rd_check("R8 mid2");
    wr_m(8'h23, "R8 s3"); rd_check("R8 after");
    chk(m_wd == 2'b01 && m_bp == 3'b100, "R8 fields", rd_data, 8'h23);

    // R6 second byte aborts
    wr_m(8'h06, "R6 arm");
    wr_start = 1; tick(); wr_start = 0;
    byte_vld = 1; byte_in = 8'h02; tick();
    chk(ack_vld && ack, "R6 first byte ack", ack, 1);
    byte_in = 8'h02; tick(); byte_vld = 0;
    chk(ack_vld && !ack, "R6 second byte nack", ack, 0);
    stop = 1; tick(); stop = 0;
    chk(!busy, "R6 no commit", busy, 0);
    rd_check("R6 state unchanged");

    // R7 bytes during busy, old fields visible
    wr(8'h63, a);
    chk(a && busy, "R7 commit start", busy, 1);
    chk(wd_sel == 2'b01, "R7 old wd during busy", wd_sel, 1);
    wr(8'h06, a);
    chk(!a, "R7 nack while busy", a, 0);
    chk(wd_sel == 2'b01, "R7 wd held", wd_sel, 1);
    while (busy) tick();
    m_rwel = 0; m_wd = 2'b11; m_bp = 3'b100;
    chk(wd_sel == 2'b11, "R11 wd after commit", wd_sel, 3);
    rd_check("R7 state after commit");

    // R9 R10 protection decode for every setting
    for (int p = 0; p < 8; p++) begin
      commit_val(2'b00, 3'(p));
      for (int ad = 0; ad < (1 << AW); ad++) begin
        mem_wr_vld = 1; mem_wr_addr = AW'(ad); tick(); mem_wr_vld = 0;
        chk(wp_hit == exp_prot(3'(p), ad), "R9 decode", wp_hit, exp_prot(3'(p), ad));
      end
      tick();
      chk(!wp_hit, "R9 idle no hit", wp_hit, 0);
      wr_m(8'h06, "R10 arm");
      mem_wr_vld = 1; mem_wr_addr = '0; tick(); mem_wr_vld = 0;
      if (exp_prot(3'(p), 0)) m_rwel = 0;
      rd_check("R10 latch after attempt");
      c = m_rwel;
      if (c) wr_m(model_byte() & 8'h7B, "R4 relock");
    end

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule